// File: doc/BRIEF.md
# Mode-Selected Synchronous Clock Divider Tree

This block takes one fast master clock and produces the clock groups of a processor board: CPU, half-rate CPU, a 66 MHz group, PCI, APIC, USB and reference. Each output pin comes with its own output-enable, so a pad ring can tri-state it. Every divided clock is cut from one free-running counter that counts 0 to 95 and wraps. The period of each group is a whole number of master cycles, and each group has a fixed rising-edge offset. This keeps the edge order between groups fixed in every mode. At the default master rate (eight times the 100 MHz CPU rate) the counter gives 133 MHz and 100 MHz CPU operation.

A three-bit select (frequency bit, high select bit, low select bit) chooses one of four behaviours: every output dark, a test mode, normal running at one of two CPU rates, or normal running with the USB output dark. In test mode the master clock stands in for the overdriven test clock, and the outputs run at fixed power-of-two ratios of the reference output. In normal modes the USB and reference pins pass through the external `usb_src` and `ref_src` clocks. The decode also produces a USB-PLL enable, an invalid-code flag and two spread-type flags that steer an external modulator.

The select pins are sampled only when the counter wraps. A new mode therefore always starts at the beginning of a frame, where every divided clock is low or starting a fresh high phase.

Top module: `clkdiv_tree`

## Requirements
- R1: While reset is held, every output-enable, every clock output and all four flags are 0, and the counter restarts at 0 after reset.
- R2: Code {freq,b1,b0} = 000 makes every enable 0 and drives every clock output to 0. This code raises no flag.
- R3: Code 100 is test mode, and every enable is 1. Periods in master cycles are: reference 2, CPU 4, USB 4, half-rate 8, 66 MHz group 8, PCI 16, APIC 32. The USB-PLL enable is 1.
- R4: The reserved codes 001 and 101 behave like code 000 and also raise `mode_invalid`. While `mode_invalid` is 1, every enable is 0.
- R5: Codes x11 run with every enable at 1 and the USB-PLL enable at 1. With freq=1 the periods are CPU 6, half-rate 12, 66 MHz 12, PCI 24 and APIC 48. With freq=0 they are CPU 8, half-rate 16, 66 MHz 12, PCI 24 and APIC 48. The USB and reference pins follow `usb_src` and `ref_src`.
- R6: Codes x10 match x11, except that the USB enable, the USB output and the USB-PLL enable are all 0.
- R7: Let an output have period P and offset D, where D is 0 for CPU, half-rate, USB and reference, 1 for the 66 MHz group and APIC, and 2 for PCI. After a clock edge at which the counter held n, the output is 1 exactly when ((n − D) mod P) < P/2. So a PCI rising edge comes one cycle after a 66 MHz rising edge and two cycles after a CPU rising edge.
- R8: With `spread_n` = 0, b1:b0 = 01 raises `spread_centre`, and b1 = 1 raises `spread_down`. With `spread_n` = 1 neither flag is raised. The two flags are never 1 together.
- R9: The select and spread pins are sampled only at the edge where the counter holds 95. Their effect on every output and flag appears after the following edge. A pin change earlier in the frame has no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (the test clock in test mode) |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 1 | Frequency bit: 1 = 133 MHz CPU, 0 = 100 MHz CPU |
| sel_b1 | input | 1 | High select bit |
| sel_b0 | input | 1 | Low select bit |
| spread_n | input | 1 | Active-low spread request |
| ref_src | input | 1 | External reference clock passed through in normal modes |
| usb_src | input | 1 | External 48 MHz clock passed through in normal modes |
| cpu_clk | output | CPU_N | CPU clocks |
| cpu_oe | output | CPU_N | CPU output enables |
| half_clk | output | HALF_N | Half-rate CPU clocks |
| half_oe | output | HALF_N | Half-rate output enables |
| mid_clk | output | MID_N | 66 MHz group clocks |
| mid_oe | output | MID_N | 66 MHz group output enables |
| pci_clk | output | PCI_N | PCI clocks |
| pci_oe | output | PCI_N | PCI output enables |
| apic_clk | output | APIC_N | APIC clocks |
| apic_oe | output | APIC_N | APIC output enables |
| usb_clk | output | 1 | USB clock |
| usb_oe | output | 1 | USB output enable |
| ref_clk | output | REF_N | Reference clocks |
| ref_oe | output | REF_N | Reference output enables |
| usb_pll_en | output | 1 | USB PLL enable |
| spread_centre | output | 1 | Centre spread requested |
| spread_down | output | 1 | Down spread requested |
| mode_invalid | output | 1 | Reserved select code in force |

## Verification
The bench runs every select code, with the spread request both ways, for a full frame each, and compares every output pin in every cycle against periods and offsets computed arithmetically. Select pins change in the middle of each frame. A design that applied a mode on the spot would emit runt pulses, and the checks after the change would catch them. A swapped period or offset between the two running rates, or a test-mode ratio off by a factor of two, shows up as a wrong level within a few cycles. A reserved code that fell through to a running mode would light enables that the bench expects dark. The spread and USB-PLL flags are checked in the frames that should raise them and in the frames that should not.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int unsigned FRAME = 96;
  localparam int unsigned CNT_W = $clog2(FRAME);
  localparam int unsigned NGRP  = 7;

  localparam int GI_CPU  = 0;
  localparam int GI_HALF = 1;
  localparam int GI_MID  = 2;
  localparam int GI_PCI  = 3;
  localparam int GI_APIC = 4;
  localparam int GI_USB  = 5;
  localparam int GI_REF  = 6;

  localparam int SEL_FAST = 0;
  localparam int SEL_SLOW = 1;
  localparam int SEL_TEST = 2;

  typedef enum logic [1:0] {
    MD_OFF  = 2'd0,
    MD_TEST = 2'd1,
    MD_RUN  = 2'd2
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  fast;
    logic  usb_on;
    logic  invalid;
    logic  centre;
    logic  down;
  } cfg_t;

  // Select pins to configuration.
  function automatic cfg_t decode_select(input logic fs, input logic s1,
                                         input logic s0, input logic spread_n);
    cfg_t c;
    c = '0;
    if (s1) begin
      c.mode   = MD_RUN;
      c.fast   = fs;
      c.usb_on = s0;
    end else if (fs && !s0) begin
      c.mode   = MD_TEST;
      c.usb_on = 1'b1;
    end else if (s0) begin
      c.invalid = 1'b1;
    end
    c.centre = !spread_n && !s1 && s0;
    c.down   = !spread_n && s1;
    return c;
  endfunction

  // Period in master cycles; 0 means the lane is not divided in that mode.
  function automatic int unsigned period_of(input int g, input int sel);
    int unsigned p;
    p = 0;
    case (sel)
      SEL_FAST: case (g)
        GI_CPU: p = 6;  GI_HALF: p = 12; GI_MID: p = 12;
        GI_PCI: p = 24; GI_APIC: p = 48; default: p = 0;
      endcase
      SEL_SLOW: case (g)
        GI_CPU: p = 8;  GI_HALF: p = 16; GI_MID: p = 12;
        GI_PCI: p = 24; GI_APIC: p = 48; default: p = 0;
      endcase
      default: case (g)
        GI_REF: p = 2;  GI_CPU: p = 4;  GI_USB: p = 4;
        GI_HALF: p = 8; GI_MID: p = 8;  GI_PCI: p = 16;
        GI_APIC: p = 32; default: p = 0;
      endcase
    endcase
    return p;
  endfunction

  // Rising-edge offset, fixing CPU -> 66 MHz -> PCI order.
  function automatic int unsigned offset_of(input int g);
    int unsigned d;
    case (g)
      GI_MID, GI_APIC: d = 1;
      GI_PCI:          d = 2;
      default:         d = 0;
    endcase
    return d;
  endfunction

  function automatic logic wave_at(input logic [CNT_W-1:0] n,
                                   input int unsigned per, input int unsigned off);
    int unsigned ph;
    if (per == 0) return 1'b0;
    ph = (32'(n) + FRAME - off) % per;
    return ph < (per / 2);
  endfunction

  function automatic logic group_enabled(input cfg_t c, input int g);
    logic e;
    case (c.mode)
      MD_TEST: e = 1'b1;
      MD_RUN:  e = (g == GI_USB) ? c.usb_on : 1'b1;
      default: e = 1'b0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/cdt_frame_counter.sv
module cdt_frame_counter
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME - 1);

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R9: the frame counter never leaves its range
  p_cnt_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/cdt_mode_reg.sv
module cdt_mode_reg
  import cdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic freq_sel,
  input  logic sel_b1,
  input  logic sel_b0,
  input  logic spread_n,
  output cfg_t cfg_q
);

  cfg_t cfg_d;

  assign cfg_d = decode_select(freq_sel, sel_b1, sel_b0, spread_n);

  always_ff @(posedge clk) begin
    if (!rst_n)    cfg_q <= '0;
    else if (wrap) cfg_q <= cfg_d;
  end

  // R9: configuration moves only on the wrap edge
  p_cfg_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> $past(wrap));

endmodule

// File: rtl/cdt_div_lane.sv
module cdt_div_lane
  import cdt_pkg::*;
#(
  parameter int unsigned P_FAST = 6,
  parameter int unsigned P_SLOW = 8,
  parameter int unsigned P_TEST = 4,
  parameter int unsigned OFFS   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  mode_e            mode,
  input  logic             fast,
  output logic             q
);

  logic w_fast, w_slow, w_test, nxt;

  assign w_fast = wave_at(cnt, P_FAST, OFFS);
  assign w_slow = wave_at(cnt, P_SLOW, OFFS);
  assign w_test = wave_at(cnt, P_TEST, OFFS);

  always_comb begin
    case (mode)
      MD_RUN:  nxt = fast ? w_fast : w_slow;
      MD_TEST: nxt = w_test;
      default: nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end

  // R2: a lane stays low after a cycle spent in the dark mode
  p_lane_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MD_OFF) |-> !q);

endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree #(
  parameter int CPU_N  = 4,
  parameter int HALF_N = 2,
  parameter int MID_N  = 4,
  parameter int PCI_N  = 7,
  parameter int APIC_N = 3,
  parameter int REF_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freq_sel,
  input  logic              sel_b1,
  input  logic              sel_b0,
  input  logic              spread_n,
  input  logic              ref_src,
  input  logic              usb_src,
  output logic [CPU_N-1:0]  cpu_clk,
  output logic [CPU_N-1:0]  cpu_oe,
  output logic [HALF_N-1:0] half_clk,
  output logic [HALF_N-1:0] half_oe,
  output logic [MID_N-1:0]  mid_clk,
  output logic [MID_N-1:0]  mid_oe,
  output logic [PCI_N-1:0]  pci_clk,
  output logic [PCI_N-1:0]  pci_oe,
  output logic [APIC_N-1:0] apic_clk,
  output logic [APIC_N-1:0] apic_oe,
  output logic              usb_clk,
  output logic              usb_oe,
  output logic [REF_N-1:0]  ref_clk,
  output logic [REF_N-1:0]  ref_oe,
  output logic              usb_pll_en,
  output logic              spread_centre,
  output logic              spread_down,
  output logic              mode_invalid
);

  import cdt_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  cfg_t             cfg_q;
  logic [NGRP-1:0]  lane_q;
  logic [NGRP-1:0]  oe_q;
  logic             tst_q, pll_q, ctr_q, dn_q, inv_q;
  logic             ref_pick, usb_pick;

  cdt_frame_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  cdt_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap     (wrap),
    .freq_sel (freq_sel),
    .sel_b1   (sel_b1),
    .sel_b0   (sel_b0),
    .spread_n (spread_n),
    .cfg_q    (cfg_q)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_lane
    cdt_div_lane #(
      .P_FAST (period_of(g, SEL_FAST)),
      .P_SLOW (period_of(g, SEL_SLOW)),
      .P_TEST (period_of(g, SEL_TEST)),
      .OFFS   (offset_of(g))
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt),
      .mode  (cfg_q.mode),
      .fast  (cfg_q.fast),
      .q     (lane_q[g])
    );
  end

  // Enable and flag stage, aligned with the lane registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q  <= '0;
      tst_q <= 1'b0;
      pll_q <= 1'b0;
      ctr_q <= 1'b0;
      dn_q  <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      for (int g = 0; g < NGRP; g++) oe_q[g] <= group_enabled(cfg_q, g);
      tst_q <= (cfg_q.mode == MD_TEST);
      pll_q <= cfg_q.usb_on;
      ctr_q <= cfg_q.centre;
      dn_q  <= cfg_q.down;
      inv_q <= cfg_q.invalid;
    end
  end

  assign ref_pick = tst_q ? lane_q[GI_REF] : ref_src;
  assign usb_pick = tst_q ? lane_q[GI_USB] : usb_src;

  assign cpu_clk  = {CPU_N{lane_q[GI_CPU] & oe_q[GI_CPU]}};
  assign cpu_oe   = {CPU_N{oe_q[GI_CPU]}};
  assign half_clk = {HALF_N{lane_q[GI_HALF] & oe_q[GI_HALF]}};
  assign half_oe  = {HALF_N{oe_q[GI_HALF]}};
  assign mid_clk  = {MID_N{lane_q[GI_MID] & oe_q[GI_MID]}};
  assign mid_oe   = {MID_N{oe_q[GI_MID]}};
  assign pci_clk  = {PCI_N{lane_q[GI_PCI] & oe_q[GI_PCI]}};
  assign pci_oe   = {PCI_N{oe_q[GI_PCI]}};
  assign apic_clk = {APIC_N{lane_q[GI_APIC] & oe_q[GI_APIC]}};
  assign apic_oe  = {APIC_N{oe_q[GI_APIC]}};
  assign usb_clk  = usb_pick & oe_q[GI_USB];
  assign usb_oe   = oe_q[GI_USB];
  assign ref_clk  = {REF_N{ref_pick & oe_q[GI_REF]}};
  assign ref_oe   = {REF_N{oe_q[GI_REF]}};

  assign usb_pll_en    = pll_q;
  assign spread_centre = ctr_q;
  assign spread_down   = dn_q;
  assign mode_invalid  = inv_q;

  // R7: a PCI rising edge follows a 66 MHz rising edge by one cycle
  p_pci_trails_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_q[GI_PCI]) |-> $past($rose(lane_q[GI_MID])));

  // R7: a PCI rising edge follows a CPU rising edge by two cycles
  p_pci_trails_cpu_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_q[GI_PCI]) |-> $past($rose(lane_q[GI_CPU]), 2));

  // R4: a reserved code leaves every pad undriven
  p_invalid_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q |-> (oe_q == '0));

  // R8: centre and down spread are exclusive
  p_spread_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctr_q, dn_q}));

endmodule

// File: tb/clkdiv_tree_bench.sv
module clkdiv_tree_bench;

  localparam int CPU_N = 4, HALF_N = 2, MID_N = 4, PCI_N = 7, APIC_N = 3, REF_N = 2;
  localparam int NFR = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, fs, s1, s0, spn, ref_src, usb_src;
  logic [CPU_N-1:0]  cpu_clk, cpu_oe;
  logic [HALF_N-1:0] half_clk, half_oe;
  logic [MID_N-1:0]  mid_clk, mid_oe;
  logic [PCI_N-1:0]  pci_clk, pci_oe;
  logic [APIC_N-1:0] apic_clk, apic_oe;
  logic              usb_clk, usb_oe;
  logic [REF_N-1:0]  ref_clk, ref_oe;
  logic              usb_pll_en, spread_centre, spread_down, mode_invalid;

  clkdiv_tree #(.CPU_N(CPU_N), .HALF_N(HALF_N), .MID_N(MID_N), .PCI_N(PCI_N),
                .APIC_N(APIC_N), .REF_N(REF_N)) u_clkdiv_tree (
    .clk(clk), .rst_n(rst_n), .freq_sel(fs), .sel_b1(s1), .sel_b0(s0),
    .spread_n(spn), .ref_src(ref_src), .usb_src(usb_src),
    .cpu_clk(cpu_clk), .cpu_oe(cpu_oe), .half_clk(half_clk), .half_oe(half_oe),
    .mid_clk(mid_clk), .mid_oe(mid_oe), .pci_clk(pci_clk), .pci_oe(pci_oe),
    .apic_clk(apic_clk), .apic_oe(apic_oe), .usb_clk(usb_clk), .usb_oe(usb_oe),
    .ref_clk(ref_clk), .ref_oe(ref_oe), .usb_pll_en(usb_pll_en),
    .spread_centre(spread_centre), .spread_down(spread_down),
    .mode_invalid(mode_invalid));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rep(input int n, input logic b);
    return b ? 16'((32'd1 << n) - 1) : 16'd0;
  endfunction

  // md: 0 dark, 1 test, 2 run 133, 3 run 100
  function automatic int per_of(input int md, input int g);
    int t[5], f[5], s[5];
    t = '{4, 8, 8, 16, 32};
    f = '{6, 12, 12, 24, 48};
    s = '{8, 16, 12, 24, 48};
    if (md == 1) return t[g];
    if (md == 2) return f[g];
    return s[g];
  endfunction

  function automatic int off_of(input int g);
    if (g == 3) return 2;
    if (g == 2 || g == 4) return 1;
    return 0;
  endfunction

  function automatic logic bw(input int per, input int off, input int n);
    int ph;
    ph = (n + 96 - off) % per;
    return ph < per / 2;
  endfunction

  task automatic check_cycle(input logic [2:0] code, input logic sp, input int n,
                             input bit pend);
    int md; bit inval, usb_en, ctr, dn;
    logic e[7]; logic eo[7];
    string base, rq;
    md = 0; inval = 0;
    if (code[1]) md = code[2] ? 2 : 3;
    else if (code == 3'b100) md = 1;
    else if (code[0]) inval = 1;
    usb_en = (md == 1) || (md >= 2 && code[0]);
    ctr = !sp && (code[1:0] == 2'b01);
    dn  = !sp && code[1];
    for (int g = 0; g < 5; g++) e[g] = (md == 0) ? 1'b0 : bw(per_of(md, g), off_of(g), n);
    e[5] = (md == 1) ? bw(4, 0, n) : (md >= 2 && code[0]) ? usb_src : 1'b0;
    e[6] = (md == 1) ? bw(2, 0, n) : (md >= 2) ? ref_src : 1'b0;
    for (int g = 0; g < 7; g++) eo[g] = (md == 0) ? 1'b0 : (g == 5) ? usb_en : 1'b1;
    base = (md == 1) ? "R3" : (md >= 2) ? (code[0] ? "R5" : "R6") : (inval ? "R4" : "R2");
    rq = pend ? {base, "/R7/R9"} : {base, "/R7"};
    chk(rq, "cpu_clk",  16'(cpu_clk),  rep(CPU_N, e[0]));
    chk(rq, "half_clk", 16'(half_clk), rep(HALF_N, e[1]));
    chk(rq, "mid_clk",  16'(mid_clk),  rep(MID_N, e[2]));
    chk(rq, "pci_clk",  16'(pci_clk),  rep(PCI_N, e[3]));
    chk(rq, "apic_clk", 16'(apic_clk), rep(APIC_N, e[4]));
    chk(rq, "usb_clk",  16'(usb_clk),  rep(1, e[5]));
    chk(rq, "ref_clk",  16'(ref_clk),  rep(REF_N, e[6]));
    chk(base, "cpu_oe",  16'(cpu_oe),  rep(CPU_N, eo[0]));
    chk(base, "half_oe", 16'(half_oe), rep(HALF_N, eo[1]));
    chk(base, "mid_oe",  16'(mid_oe),  rep(MID_N, eo[2]));
    chk(base, "pci_oe",  16'(pci_oe),  rep(PCI_N, eo[3]));
    chk(base, "apic_oe", 16'(apic_oe), rep(APIC_N, eo[4]));
    chk(base, "usb_oe",  16'(usb_oe),  rep(1, eo[5]));
    chk(base, "ref_oe",  16'(ref_oe),  rep(REF_N, eo[6]));
    chk("R6", "usb_pll_en",   16'(usb_pll_en),    16'(usb_en));
    chk("R4", "mode_invalid", 16'(mode_invalid),  16'(inval));
    chk("R8", "spread_centre", 16'(spread_centre), 16'(ctr));
    chk("R8", "spread_down",   16'(spread_down),   16'(dn));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic [3:0] plan [NFR];
    logic [2:0] cur; logic cur_sp;
    logic [2:0] nx;  logic nx_sp;
    // {freq,b1,b0,spread_n}
    plan = '{4'b1110, 4'b0111, 4'b1100, 4'b0101, 4'b1000,
             4'b0010, 4'b0001, 4'b1011, 4'b1111, 4'b0110};
    rst_n = 1'b0; fs = 1'b0; s1 = 1'b0; s0 = 1'b0; spn = 1'b1;
    ref_src = 1'b0; usb_src = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "all enables", 16'({cpu_oe, half_oe, mid_oe, pci_oe}), 16'd0);
    chk("R1", "other enables", 16'({apic_oe, usb_oe, ref_oe}), 16'd0);
    chk("R1", "all clocks", 16'({cpu_clk, half_clk, mid_clk, pci_clk}), 16'd0);
    chk("R1", "flags", 16'({usb_pll_en, spread_centre, spread_down, mode_invalid}), 16'd0);
    rst_n = 1'b1;
    cur = 3'b000; cur_sp = 1'b1;
    for (int f = 0; f <= NFR; f++) begin
      if (f < NFR) begin nx = plan[f][3:1]; nx_sp = plan[f][0]; end
      else begin nx = cur; nx_sp = cur_sp; end
      for (int n = 0; n < 96; n++) begin
        @(posedge clk);
        @(negedge clk);
        check_cycle(cur, cur_sp, n, (n > 40) && ({nx, nx_sp} != {cur, cur_sp}));
        if (n == 40) begin
          fs = nx[2]; s1 = nx[1]; s0 = nx[0]; spn = nx_sp;
        end
        ref_src = ((n / 3) % 2) == 1;
        usb_src = ((n / 5) % 2) == 1;
      end
      cur = nx; cur_sp = nx_sp;
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got hung expected completion");
      summary();
      $finish;
    end
  end

endmodule